// File: doc/BRIEF.md
# Grouped Match-Timer Channels

This block provides eight match channels, numbered 4 to 11, for a system timer. Each channel owns a 32-bit match register, a 32-bit counter register and a control register. By default a channel compares against the counter of the base channel of its group, which is channel 4 for channels 4–7, channel 8 for 8–9 and channel 10 for 10–11. When its own-counter bit is set, the channel compares against a counter of its own. Each running counter advances on single-cycle enable pulses from one of five tick sources, chosen in its control register. The tick sources themselves are produced outside the block.

On a match, the control register decides what follows. The counter can be cleared, the channel can stay armed for the next match, or it can fire once and then wait until it is re-armed. A snapshot register captures the count of channel 8 or channel 10 when counter 9 or counter 11 is read, so software can read a pair of counts together. Match events set per-channel status bits, gated by enable bits. One combined interrupt stays high while any of these status bits is set.

Software reaches the block through a simple register port. A write takes effect at the clock edge where `bus_wr` is sampled high. Read data appears on `bus_rdata` one cycle after `bus_rd`.

Top module: `xmatch_timer`

## Requirements
- R1: After reset, every register reads 0 and `irq_ext` is low.
- R2: Register addresses, with n from 4 to 11:
  - match n is at 0x80+4·(n−4), counter n at 0x40+4·(n−4), control n at 0xC0+4·(n−4);
  - snapshot is at 0x20, status at 0x14 and enable at 0x1C.
  - Control registers of channels 4–7 keep bits [7:0]. Those of channels 8–11 keep bits [9:0]. The dropped bits read as 0.
- R3: Control field [2:0] selects the tick source. A value k from 1 to 5 makes the counter advance by one on each pulse of `tick_src[k-1]`. Values 0, 6 and 7 hold the counter, and reads return the held value.
- R4: Without control bit 7, channels 5–7 compare against counter 4, channel 9 against counter 8 and channel 11 against counter 10, and their own counters hold. With bit 7 set, a channel runs and compares against its own counter.
- R5: On channels 8–11, control bit 8 set holds the counter whatever field [2:0] selects.
- R6: A match is the counter stepping onto the match value. It sets status bit n one clock edge later, but only if enable bit n is set. Status and enable bits occupy positions [11:4], bit n for channel n.
- R7: With control bit 6 clear, a channel fires once and then ignores further matches until it is re-armed. With bit 6 set, it fires on every match.
- R8: With control bit 3 set, a match clears the counter the channel compares against, at the same edge that sets the status bit.
- R9: Writing a counter loads the value at once, taking priority over a tick in the same cycle. It also re-arms every channel that compares against that counter. Writing a match register re-arms that channel.
- R10: Reading counter 9 while bit 9 of control 9 is set copies counter 8 into the snapshot register. Reading counter 11 while bit 9 of control 11 is set copies counter 10. Any other read leaves the snapshot unchanged.
- R11: `irq_ext` is high while any status bit is set. Writing 1 to a status bit clears it. A new event in the same cycle wins over the clear.
- R12: Writes to unmapped addresses are ignored, and reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data, valid the cycle after `bus_rd` |
| tick_src | input | NSRC | Tick-source enable pulses, one cycle wide |
| irq_ext | output | 1 | Combined interrupt of channels 4–11 |

## Verification
Each result falls due a fixed number of edges after its stimulus:
- A tick pulse changes the counter at the edge that samples it.
- The match found on that new count sets its status bit, raises `irq_ext` and applies any clear-on-match at the following edge.
- A read strobe delivers its data, and takes its snapshot, at the edge that samples it.

The bench drives inputs and samples outputs on falling edges. After every tick it waits exactly one more edge before checking status or the interrupt, so each check lands on the first cycle in which its result is due.

// File: rtl/xmt_pkg.sv
// Package: shared constants, control-field positions and group mapping
// for the grouped match-timer channels.
// Assumes eight channels in fixed groups {4..7}, {8,9}, {10,11}; local
// index 0..7 stands for channel 4..11.
package xmt_pkg;
    localparam int XMT_NCH   = 8;
    localparam int XMT_CTRLW = 10;

    // control bit positions, fixed by software
    localparam int B_RST  = 3;   // clear counter on match
    localparam int B_PER  = 6;   // stay armed after a match
    localparam int B_OWN  = 7;   // use own counter
    localparam int B_HALT = 8;   // force stop (channels 8..11)
    localparam int B_SNAP = 9;   // snapshot partner on read (9, 11)

    typedef logic [XMT_CTRLW-1:0] xmt_ctrl_t;

    // local index of the base channel in the group of local index i
    function automatic int unsigned grp_base(input int unsigned i);
        return (i < 4) ? 0 : ((i < 6) ? 4 : 6);
    endfunction

    // true when local index i is the base channel of its group
    function automatic bit is_base(input int unsigned i);
        return grp_base(i) == i;
    endfunction
endpackage

// File: rtl/xmt_counter.sv
// Module: one channel counter.
// Advances by one on the pulse of the tick source picked by sel (1..NSRC),
// holds for other sel values or when run is low. A load has priority over
// a clear, and a clear over a tick. stepped marks a count produced by a tick.
module xmt_counter #(
    parameter int CNT_W = 32,
    parameter int NSRC  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [2:0]       sel,
    input  logic [NSRC-1:0]  tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt,
    output logic             stepped
);
    logic adv;

    // pick the selected tick pulse
    always_comb begin
        adv = 1'b0;
        for (int s = 0; s < NSRC; s++)
            if (sel == 3'(s + 1) && tick[s]) adv = run;
    end

    // counter register with load > clear > tick priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            stepped <= 1'b0;
        end else if (load) begin
            cnt     <= load_val;
            stepped <= 1'b0;
        end else if (clr) begin
            cnt     <= '0;
            stepped <= 1'b0;
        end else if (adv) begin
            cnt     <= cnt + 1'b1;
            stepped <= 1'b1;
        end else begin
            stepped <= 1'b0;
        end
    end

    assert_hold_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !clr && !adv) |=> $stable(cnt));
endmodule

// File: rtl/xmt_compare.sv
// Module: match comparator with arming for one channel.
// A hit is the source counter stepping onto the match value while armed.
// Without periodic mode a hit disarms; arm re-arms and wins over a hit.
module xmt_compare #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] match,
    input  logic [CNT_W-1:0] cnt,
    input  logic             stepped,
    input  logic             periodic,
    input  logic             arm,
    output logic             hit
);
    logic armed;

    // match detection on a freshly stepped count
    assign hit = armed && stepped && (cnt == match);

    // arm state: set on rewrite, dropped by a one-shot hit
    always_ff @(posedge clk) begin
        if (!rst_n)                armed <= 1'b0;
        else if (arm)              armed <= 1'b1;
        else if (hit && !periodic) armed <= 1'b0;
    end

    assert_oneshot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !periodic && !arm) |=> !hit);
endmodule

// File: rtl/xmt_irq.sv
// Module: status and enable bits with the combined interrupt.
// A hit sets its status bit when enabled. Writing 1 to a status bit clears
// it, and a same-cycle set wins. The interrupt is the OR of status.
module xmt_irq #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] hit,
    input  logic           en_wr,
    input  logic [NCH-1:0] en_wdata,
    input  logic           st_wr,
    input  logic [NCH-1:0] st_wdata,
    output logic [NCH-1:0] en_q,
    output logic [NCH-1:0] status_q,
    output logic           irq
);
    logic [NCH-1:0] set_v;
    logic [NCH-1:0] clr_v;

    assign set_v = hit & en_q;
    assign clr_v = st_wr ? st_wdata : '0;
    assign irq   = |status_q;

    // enable register
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (en_wr) en_q <= en_wdata;
    end

    // status register, set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr_v) | set_v;
    end

    for (genvar k = 0; k < NCH; k++) begin : g_chk
        assert_set_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(status_q[k]) |-> $past(en_q[k] && hit[k]));
    end

    assert_irq_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && ((st_wdata & status_q) == status_q) && (set_v == '0)) |=> !irq);
endmodule

// File: rtl/xmatch_timer.sv
// Module: grouped match-timer channels 4..11 (top).
// Decodes the register port, routes each channel to its own or its group's
// counter, compares, clears on match, snapshots partner counts and merges
// events into one interrupt. Assumes one access per cycle; read data is
// registered and valid the cycle after bus_rd.
module xmatch_timer
    import xmt_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8,
    parameter int NSRC   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic [NSRC-1:0]   tick_src,
    output logic              irq_ext
);
    localparam int NCH     = XMT_NCH;
    localparam int A_MATCH = 'h80;
    localparam int A_COUNT = 'h40;
    localparam int A_CTRL  = 'hC0;
    localparam int A_SNAP  = 'h20;
    localparam int A_STAT  = 'h14;
    localparam int A_EN    = 'h1C;
    localparam int BIT_LO  = 4;

    logic [CNT_W-1:0] match_q [NCH];
    xmt_ctrl_t        ctrl_q  [NCH];
    logic [CNT_W-1:0] cnt_w   [NCH];
    logic [NCH-1:0]   stepped_w;
    logic [2:0]       src_idx [NCH];
    logic [NCH-1:0]   wr_match, wr_count, wr_ctrl, hit, arm, clr;
    logic [NCH-1:0]   en_q, status_q;
    logic [CNT_W-1:0] snap_q, rd_val;
    logic             snap_take;
    logic [CNT_W-1:0] snap_src;

    // address decode for per-channel writes
    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            wr_match[i] = bus_wr && bus_addr == ADDR_W'(A_MATCH + 4 * i);
            wr_count[i] = bus_wr && bus_addr == ADDR_W'(A_COUNT + 4 * i);
            wr_ctrl[i]  = bus_wr && bus_addr == ADDR_W'(A_CTRL  + 4 * i);
        end
    end

    // counter each channel compares against
    always_comb begin
        for (int i = 0; i < NCH; i++)
            src_idx[i] = (ctrl_q[i][B_OWN] || is_base(i)) ? 3'(i) : 3'(grp_base(i));
    end

    // arm on match write or on a load of the source counter
    always_comb begin
        for (int i = 0; i < NCH; i++)
            arm[i] = wr_match[i] || wr_count[src_idx[i]];
    end

    // clear-on-match routed back to the counter that matched
    always_comb begin
        clr = '0;
        for (int n = 0; n < NCH; n++)
            if (hit[n] && ctrl_q[n][B_RST]) clr[src_idx[n]] = 1'b1;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        localparam xmt_ctrl_t CMASK = (g < 4) ? xmt_ctrl_t'('h0FF) : xmt_ctrl_t'('h3FF);
        logic run;

        // match and control registers of this channel
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                match_q[g] <= '0;
                ctrl_q[g]  <= '0;
            end else begin
                if (wr_match[g]) match_q[g] <= bus_wdata;
                if (wr_ctrl[g])  ctrl_q[g]  <= xmt_ctrl_t'(bus_wdata) & CMASK;
            end
        end

        assign run = (is_base(g) || ctrl_q[g][B_OWN]) && !ctrl_q[g][B_HALT];

        xmt_counter #(.CNT_W(CNT_W), .NSRC(NSRC)) u_cnt (
            .clk(clk), .rst_n(rst_n), .run(run), .sel(ctrl_q[g][2:0]),
            .tick(tick_src), .load(wr_count[g]), .load_val(bus_wdata),
            .clr(clr[g]), .cnt(cnt_w[g]), .stepped(stepped_w[g])
        );

        xmt_compare #(.CNT_W(CNT_W)) u_cmp (
            .clk(clk), .rst_n(rst_n), .match(match_q[g]),
            .cnt(cnt_w[src_idx[g]]), .stepped(stepped_w[src_idx[g]]),
            .periodic(ctrl_q[g][B_PER]), .arm(arm[g]), .hit(hit[g])
        );
    end

    xmt_irq #(.NCH(NCH)) u_irq (
        .clk(clk), .rst_n(rst_n), .hit(hit),
        .en_wr(bus_wr && bus_addr == ADDR_W'(A_EN)),
        .en_wdata(bus_wdata[BIT_LO +: NCH]),
        .st_wr(bus_wr && bus_addr == ADDR_W'(A_STAT)),
        .st_wdata(bus_wdata[BIT_LO +: NCH]),
        .en_q(en_q), .status_q(status_q), .irq(irq_ext)
    );

    // snapshot request: read of counter 9 or 11 with its snapshot bit
    always_comb begin
        snap_take = 1'b0;
        snap_src  = cnt_w[4];
        if (bus_rd && bus_addr == ADDR_W'(A_COUNT + 4 * 5) && ctrl_q[5][B_SNAP]) begin
            snap_take = 1'b1;
            snap_src  = cnt_w[4];
        end else if (bus_rd && bus_addr == ADDR_W'(A_COUNT + 4 * 7) && ctrl_q[7][B_SNAP]) begin
            snap_take = 1'b1;
            snap_src  = cnt_w[6];
        end
    end

    // snapshot register
    always_ff @(posedge clk) begin
        if (!rst_n)         snap_q <= '0;
        else if (snap_take) snap_q <= snap_src;
    end

    // read multiplexer; unmapped addresses give 0
    always_comb begin
        rd_val = '0;
        for (int i = 0; i < NCH; i++) begin
            if (bus_addr == ADDR_W'(A_MATCH + 4 * i)) rd_val = match_q[i];
            if (bus_addr == ADDR_W'(A_COUNT + 4 * i)) rd_val = cnt_w[i];
            if (bus_addr == ADDR_W'(A_CTRL  + 4 * i)) rd_val = CNT_W'(ctrl_q[i]);
        end
        if (bus_addr == ADDR_W'(A_SNAP)) rd_val = snap_q;
        if (bus_addr == ADDR_W'(A_STAT)) rd_val = CNT_W'({status_q, 4'b0});
        if (bus_addr == ADDR_W'(A_EN))   rd_val = CNT_W'({en_q, 4'b0});
    end

    // registered read data
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_val;
    end

    assert_snap_only_on_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_take |=> $stable(snap_q));
endmodule

// File: tb/xmatch_timer_bench.sv
// Directed bench for xmatch_timer: one task per scenario, each checking
// its own results. Inputs change and outputs are sampled on falling edges.
module xmatch_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [4:0]  tick_src = '0;
    logic        irq_ext;
    int          total = 0, fails = 0;
    logic        done = 1'b0;

    always #4 clk = ~clk;

    xmatch_timer u_xmatch_timer (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_src(tick_src), .irq_ext(irq_ext)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pulse(input logic [4:0] m, input int n);
        for (int k = 0; k < n; k++) begin
            tick_src = m;
            @(negedge clk);
            tick_src = '0;
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 irq", {31'b0, irq_ext}, 0);
        rd(8'h40, v); chk("R1 counter4", v, 0);
        rd(8'hC0, v); chk("R1 control4", v, 0);
        rd(8'h20, v); chk("R1 snapshot", v, 0);
        rd(8'h14, v); chk("R1 status", v, 0);
    endtask

    task automatic t_regmap();
        logic [31:0] v;
        wr(8'hC0, 32'hFFFF_FFFF); rd(8'hC0, v); chk("R2 control4 width", v, 32'hFF);
        wr(8'hD0, 32'hFFFF_FFFF); rd(8'hD0, v); chk("R2 control8 width", v, 32'h3FF);
        wr(8'hC0, 0); wr(8'hD0, 0);
        wr(8'h8C, 32'h1234_5678); rd(8'h8C, v); chk("R2 match7", v, 32'h1234_5678);
        wr(8'h8C, 0);
        wr(8'h30, 32'hDEAD_BEEF); rd(8'h30, v); chk("R12 unmapped", v, 0);
    endtask

    task automatic t_timebase();
        logic [31:0] v;
        wr(8'hC0, 1); wr(8'h40, 0);
        rd(8'h40, v); chk("R9 load", v, 0);
        pulse(5'b00001, 3); pulse(5'b00010, 2);
        rd(8'h40, v); chk("R3 source 1", v, 3);
        wr(8'hC0, 5); pulse(5'b10000, 1); pulse(5'b01111, 1);
        rd(8'h40, v); chk("R3 source 5", v, 4);
        wr(8'hC0, 6); pulse(5'b11111, 2);
        rd(8'h40, v); chk("R3 select 6 holds", v, 4);
        wr(8'hC0, 0); pulse(5'b11111, 1);
        rd(8'h40, v); chk("R3 select 0 holds", v, 4);
    endtask

    task automatic t_group_match();
        logic [31:0] v;
        wr(8'h1C, 32'hFF0);
        wr(8'hC0, 1); wr(8'hC4, 0);
        wr(8'h84, 2); wr(8'h40, 0);
        pulse(5'b00001, 1); @(negedge clk);
        chk("R6 no early event", {31'b0, irq_ext}, 0);
        pulse(5'b00001, 1); @(negedge clk);
        chk("R11 irq on event", {31'b0, irq_ext}, 1);
        rd(8'h14, v); chk("R4 ch5 uses counter4", v, 32'h20);
        rd(8'h44, v); chk("R4 counter5 holds", v, 0);
        wr(8'h14, 32'h20); @(negedge clk);
        chk("R11 irq cleared", {31'b0, irq_ext}, 0);
    endtask

    task automatic t_periodic_reset();
        logic [31:0] v;
        wr(8'hC8, 32'h48); wr(8'h88, 3); wr(8'h40, 0);
        pulse(5'b00001, 3); @(negedge clk);
        rd(8'h40, v); chk("R8 counter cleared", v, 0);
        rd(8'h14, v); chk("R9 rearmed by counter write", v, 32'h60);
        wr(8'h14, 32'h60);
        pulse(5'b00001, 3); @(negedge clk);
        rd(8'h14, v); chk("R7 periodic fires, one-shot silent", v, 32'h40);
        wr(8'h14, 32'h40); @(negedge clk);
        chk("R11 irq low", {31'b0, irq_ext}, 0);
        wr(8'hC0, 0);
    endtask

    task automatic t_own_halt();
        logic [31:0] v;
        wr(8'hD4, 32'h82); wr(8'h54, 0);
        pulse(5'b00010, 1);
        rd(8'h54, v); chk("R4 own counter runs", v, 1);
        wr(8'hD4, 32'h182); pulse(5'b00010, 1);
        rd(8'h54, v); chk("R5 halt bit holds", v, 1);
        wr(8'hD4, 32'h02); pulse(5'b00010, 1);
        rd(8'h54, v); chk("R4 non-base holds", v, 1);
    endtask

    task automatic t_snapshot();
        logic [31:0] v;
        wr(8'hD0, 1); wr(8'h50, 32'h100);
        pulse(5'b00001, 2);
        wr(8'hD4, 32'h200);
        rd(8'h54, v); rd(8'h20, v); chk("R10 snapshot of counter8", v, 32'h102);
        wr(8'hD4, 0); pulse(5'b00001, 1);
        rd(8'h54, v); rd(8'h20, v); chk("R10 no snapshot", v, 32'h102);
        wr(8'hD0, 0);
    endtask

    task automatic t_enable();
        logic [31:0] v;
        wr(8'h1C, 32'hBF0);
        wr(8'hD8, 1); wr(8'h98, 1); wr(8'h58, 0);
        pulse(5'b00001, 1); @(negedge clk);
        chk("R6 disabled irq", {31'b0, irq_ext}, 0);
        rd(8'h14, v); chk("R6 disabled status", v, 0);
        wr(8'h1C, 32'hFF0); wr(8'h58, 0);
        pulse(5'b00001, 1); @(negedge clk);
        rd(8'h14, v); chk("R6 enabled status", v, 32'h400);
        chk("R11 irq ch10", {31'b0, irq_ext}, 1);
        wr(8'h14, 32'h400); @(negedge clk);
        chk("R11 irq ch10 cleared", {31'b0, irq_ext}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_timebase();
        t_group_match();
        t_periodic_reset();
        t_own_halt();
        t_snapshot();
        t_enable();
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule